// File: doc/BRIEF.md
# Flash Read Line Buffer Controller

This block sits between a 64-bit system read port and a flash array that returns 128-bit lines. It keeps four line buffers, each tagged with the number of the line it holds. A read whose line is already buffered is answered in the same cycle. A read that misses starts an array access. The access lasts a number of wait states picked by a speed setting. When the access ends, the line is written into a buffer and the read completes from there. After a line is fetched for a read, the controller can fetch the following line ahead of time into another buffer, so that a sequential reader sees no wait.

The read port is a valid/ready channel whose data is returned in the handshake cycle. The requester raises `req_valid` with a byte address and keeps both steady until it sees `req_ready` high at a clock edge. The controller applies back-pressure by holding `req_ready` low for as long as the data is not buffered. Only one read is open at a time. `req_valid` may stay high across back-to-back reads, with a new address presented in the cycle after a handshake. The flash array is a behavioural model inside the block. Its content is a fixed function of the line number. It must see its line address held for the whole wait window, and it is sampled at the end of that window.

Top module: `flash_prefetch_ctrl`

## Requirements
- R1: When `req_valid` is high and the addressed line is held in a valid buffer, `req_ready` is high in that same cycle (zero wait states).
- R2: Byte address bit 3 selects the returned half of the 128-bit line (1 = upper 64 bits, 0 = lower 64 bits). Address bits [2:0] have no effect on the data.
- R3: A read that misses while the array is idle sees exactly N cycles with `req_ready` low before the handshake cycle. N depends on `speed_sel`: 0 gives 1, 1 gives 2, and 2 or 3 give 3. The setting is taken when the array access begins.
- R4: For line number n, the returned half h equals {16'hF1A5, 15'b0, h, n as 32 bits}, where h is the half bit, placed at bit 32.
- R5: A fetched line goes into the lowest-numbered empty buffer. When all four are full, it goes into the buffer used least recently. A hit and a fill both count as a use.
- R6: With `pf_en` high when a read's line n is filled, line n+1 (wrapping from the top line to line 0) is fetched from the second cycle after that fill, if the array is free and no read is missing. A later read of n+1 then hits. With `pf_en` low, no line is fetched ahead. A fetch-ahead whose line is already buffered is dropped.
- R7: A missing read beats a waiting fetch-ahead for the array. A newer read fill replaces the waiting fetch-ahead target. An array access already running is never aborted by a read.
- R8: `inv_all` high at a clock edge empties all buffers and drops any running array access and any waiting fetch-ahead. A read stalled across it restarts its access in the next cycle.
- R9: After reset no buffer is valid, so the first read misses. `req_ready` is never high unless the data is buffered, and the array serves one access at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | AW (20) | Byte address of the 64-bit read |
| req_ready | output | 1 | Read completes this cycle; `rsp_data` valid |
| rsp_data | output | 64 | Read data, valid while `req_ready` is high |
| speed_sel | input | 2 | Clock speed setting that selects the miss wait count |
| pf_en | input | 1 | Enables fetch-ahead of the next line |
| inv_all | input | 1 | Empties all buffers and drops array work |

## Verification
The two functions that can fall in the same cycle are a missing read and the launch of a waiting fetch-ahead, both of which want the idle array. The bench provokes this by keeping `req_valid` high straight from one missed read into a read of an unrelated line. The second request therefore lands in the first cycle the fetch-ahead is allowed to start. The outcome is judged by the second read taking exactly the plain miss count, and by the displaced fetch-ahead line later missing while the line after the second read hits.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

  localparam int BUS_W  = 64;
  localparam int LINE_W = 128;

  // Behavioural flash content: one 64-bit half of a line.
  function automatic logic [BUS_W-1:0] line_word(input logic [31:0] line_no,
                                                 input logic        half);
    return {16'hF1A5, 15'd0, half, line_no};
  endfunction

endpackage

// File: rtl/fpb_array_model.sv
// Flash array read model: the line address must be held over the wait
// window; the controller samples the data at the window end.
module fpb_array_model
  import fpb_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic [LW-1:0]     rd_line,
  output logic [LINE_W-1:0] rd_data
);

  always_comb begin
    rd_data = {line_word(32'(rd_line), 1'b1), line_word(32'(rd_line), 1'b0)};
  end

endmodule

// File: rtl/fpb_lru.sv
// Recency ranks (0 = most recent) with empty-slot-first victim choice.
module fpb_lru #(
  parameter int NBUF = 4,
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] vld,
  input  logic            hit_en,
  input  logic [IW-1:0]   hit_idx,
  input  logic            fill_en,
  output logic [IW-1:0]   victim
);

  typedef logic [NBUF-1:0][IW-1:0] rank_t;

  rank_t rank_q, rank_a, rank_n;
  logic  any_free;

  function automatic rank_t touch(input rank_t r, input logic [IW-1:0] e);
    rank_t o;
    o = r;
    for (int j = 0; j < NBUF; j++) begin
      if (r[j] < r[e]) o[j] = r[j] + 1'b1;
    end
    o[e] = '0;
    return o;
  endfunction

  always_comb begin
    rank_a = hit_en ? touch(rank_q, hit_idx) : rank_q;
    any_free = 1'b0;
    victim   = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        any_free = 1'b1;
        victim   = IW'(i);
      end
    end
    if (!any_free) begin
      for (int i = 0; i < NBUF; i++) begin
        if (rank_a[i] == IW'(NBUF - 1)) victim = IW'(i);
      end
    end
    rank_n = fill_en ? touch(rank_a, victim) : rank_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) rank_q[i] <= IW'(i);
    end else begin
      rank_q <= rank_n;
    end
  end

endmodule

// File: rtl/fpb_seq.sv
// Array sequencer: arbitration between demand misses and fetch-ahead,
// wait-state window, and fetch-ahead arming.
module fpb_seq #(
  parameter int LW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv,
  input  logic          dem_miss,
  input  logic [LW-1:0] dem_line,
  input  logic          pf_en,
  input  logic          pf_present,
  input  logic [CW-1:0] wait_n,
  output logic [LW-1:0] arr_line,
  output logic [LW-1:0] pf_line,
  output logic          fill_en,
  output logic          busy,
  output logic          pf_busy
);

  logic          busy_q, pf_q, pend_q, arm_q;
  logic [CW-1:0] cnt_q, cur_cnt;
  logic [LW-1:0] line_q, pend_line_q;
  logic          start_dem, pf_slot, start_pf, act, cur_pf, done;

  always_comb begin
    start_dem = !busy_q && dem_miss;
    pf_slot   = !busy_q && !dem_miss && pend_q && arm_q;
    start_pf  = pf_slot && !pf_present;
    act       = busy_q || start_dem || start_pf;
    arr_line  = busy_q ? line_q : (start_dem ? dem_line : pend_line_q);
    cur_pf    = busy_q ? pf_q : start_pf;
    cur_cnt   = busy_q ? cnt_q : (wait_n - 1'b1);
    done      = act && (cur_cnt == '0);
    fill_en   = done && !inv;
  end

  assign pf_line = pend_line_q;
  assign busy    = busy_q;
  assign pf_busy = busy_q && pf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      pf_q        <= 1'b0;
      cnt_q       <= '0;
      line_q      <= '0;
      pend_q      <= 1'b0;
      arm_q       <= 1'b0;
      pend_line_q <= '0;
    end else if (inv) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (done) begin
        busy_q <= 1'b0;
      end else if (act) begin
        busy_q <= 1'b1;
        cnt_q  <= cur_cnt - 1'b1;
        line_q <= arr_line;
        pf_q   <= cur_pf;
      end
      arm_q <= 1'b1;
      if (done && !cur_pf && pf_en) begin
        pend_q      <= 1'b1;
        pend_line_q <= arr_line + 1'b1;
        arm_q       <= 1'b0;
      end else if (pf_slot) begin
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/flash_prefetch_ctrl.sv
module flash_prefetch_ctrl
  import fpb_pkg::*;
#(
  parameter int AW       = 20,
  parameter int NBUF     = 4,
  parameter int WAIT_LO  = 1,
  parameter int WAIT_MID = 2,
  parameter int WAIT_HI  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  output logic             req_ready,
  output logic [BUS_W-1:0] rsp_data,
  input  logic [1:0]       speed_sel,
  input  logic             pf_en,
  input  logic             inv_all
);

  localparam int LW = AW - 4;
  localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int CW = $clog2(WAIT_HI + 1);

  logic [NBUF-1:0]              vld_q;
  logic [NBUF-1:0][LW-1:0]      tag_q;
  logic [NBUF-1:0][LINE_W-1:0]  dat_q;
  logic [NBUF-1:0]              hit_vec, pfp_vec;
  logic [LW-1:0]                req_line, arr_line, pf_line;
  logic [LINE_W-1:0]            arr_data, hit_line;
  logic [IW-1:0]                hit_idx, victim;
  logic [CW-1:0]                wait_n;
  logic                         hit_any, fill_en, seq_busy, seq_pf_busy;
  logic [2:0]                   unused_low;

  assign req_line   = req_addr[AW-1:4];
  assign unused_low = req_addr[2:0];

  always_comb begin
    case (speed_sel)
      2'd0:    wait_n = CW'(WAIT_LO);
      2'd1:    wait_n = CW'(WAIT_MID);
      default: wait_n = CW'(WAIT_HI);
    endcase
  end

  // Per-buffer tag compare and storage
  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    assign hit_vec[i] = vld_q[i] && (tag_q[i] == req_line);
    assign pfp_vec[i] = vld_q[i] && (tag_q[i] == pf_line);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end else if (inv_all) begin
        vld_q[i] <= 1'b0;
      end else if (fill_en && (victim == IW'(i))) begin
        vld_q[i] <= 1'b1;
        tag_q[i] <= arr_line;
        dat_q[i] <= arr_data;
      end
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
    hit_any   = |hit_vec;
    hit_line  = dat_q[hit_idx];
    req_ready = req_valid && hit_any;
    rsp_data  = req_addr[3] ? hit_line[LINE_W-1:BUS_W] : hit_line[BUS_W-1:0];
  end

  fpb_lru #(.NBUF(NBUF)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (vld_q),
    .hit_en  (req_ready),
    .hit_idx (hit_idx),
    .fill_en (fill_en),
    .victim  (victim)
  );

  fpb_seq #(.LW(LW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv        (inv_all),
    .dem_miss   (req_valid && !hit_any),
    .dem_line   (req_line),
    .pf_en      (pf_en),
    .pf_present (|pfp_vec),
    .wait_n     (wait_n),
    .arr_line   (arr_line),
    .pf_line    (pf_line),
    .fill_en    (fill_en),
    .busy       (seq_busy),
    .pf_busy    (seq_pf_busy)
  );

  fpb_array_model #(.LW(LW)) u_array (
    .rd_line (arr_line),
    .rd_data (arr_data)
  );

endmodule

// File: rtl/fpb_checker.sv
module fpb_checker #(
  parameter int NBUF = 4,
  parameter int LW   = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     inv_all,
  input logic [NBUF-1:0]          vld,
  input logic [NBUF-1:0][LW-1:0]  tags,
  input logic                     busy,
  input logic                     pf_busy
);

  // R8: buffers are empty after an invalidate edge
  a_r8_inv_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld == '0));

  // R8: running array access is dropped by invalidate
  a_r8_inv_drops_access: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !busy);

  // R7: an idle array goes to a stalled read, never to a fetch-ahead
  a_r7_demand_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !busy && !inv_all) |=>
      (req_ready || (busy && !pf_busy)));

  // R9: data is only returned from a valid buffer
  a_r9_ready_needs_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (vld != '0));

  // R5: a line never sits in two valid buffers
  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NBUF; i++) begin
        for (int j = i + 1; j < NBUF; j++) begin
          a_r5_no_dup: assert (!(vld[i] && vld[j] && tags[i] == tags[j]));
        end
      end
    end
  end

endmodule

bind flash_prefetch_ctrl fpb_checker #(.NBUF(NBUF), .LW(LW)) u_fpb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .inv_all   (inv_all),
  .vld       (vld_q),
  .tags      (tag_q),
  .busy      (seq_busy),
  .pf_busy   (seq_pf_busy)
);

// File: tb/flash_prefetch_ctrl_bench.sv
`timescale 1ns/1ps
module flash_prefetch_ctrl_bench;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready;
  logic [63:0]   rsp_data;
  logic [1:0]    speed_sel = 2'd0;
  logic          pf_en = 1'b0;
  logic          inv_all = 1'b0;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  flash_prefetch_ctrl u_flash_prefetch_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_data(rsp_data), .speed_sel(speed_sel),
    .pf_en(pf_en), .inv_all(inv_all)
  );

  function automatic int wmap(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 3;
  endfunction

  function automatic logic [63:0] expw(input int ln, input bit h);
    logic [31:0] up;
    up = 32'hF1A5_0000 | 32'(h);
    return {up, 32'(ln)};
  endfunction

  function automatic logic [AW-1:0] mk(input int ln, input bit h, input int lo);
    return AW'((ln << 4) | (int'(h) << 3) | (lo & 7));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clean();
    inv_all = 1'b1;
    @(posedge clk); #1;
    inv_all = 1'b0;
    @(posedge clk); #1;
  endtask

  // Called at posedge+1. Returns data and the number of stalled cycles.
  task automatic do_read(input logic [AW-1:0] a, input int inv_cyc, input bit keep,
                         output logic [63:0] d, output int w);
    req_valid = 1'b1;
    req_addr  = a;
    w = 0;
    inv_all = (inv_cyc == 0);
    forever begin
      @(negedge clk);
      if (req_ready) begin
        d = rsp_data;
        break;
      end
      w++;
      @(posedge clk); #1;
      inv_all = (w == inv_cyc);
    end
    @(posedge clk); #1;
    inv_all = 1'b0;
    if (!keep) req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    int w;
    void'($urandom(32'd7531));

    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 ready low in reset", 64'(req_ready), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(1);

    // R9/R3: first read misses; R4 data
    speed_sel = 2'd0;
    do_read(mk(5, 0, 0), -1, 0, d, w);
    chk("R9 first read misses", 64'(w), 64'd1);
    chk("R4 miss data", d, expw(5, 0));
    // R1 hit, R2 half select and low bits ignored
    do_read(mk(5, 0, 0), -1, 0, d, w);
    chk("R1 hit zero wait", 64'(w), 64'd0);
    do_read(mk(5, 1, 0), -1, 0, d, w);
    chk("R2 upper half", d, expw(5, 1));
    do_read(mk(5, 1, 5), -1, 0, d, w);
    chk("R2 low bits ignored", d, expw(5, 1));
    chk("R1 hit with low bits", 64'(w), 64'd0);

    // R3: wait count per speed setting
    for (int s = 0; s < 4; s++) begin
      clean();
      speed_sel = 2'(s);
      do_read(mk(16'h40 + s, 0, 0), -1, 0, d, w);
      chk($sformatf("R3 waits speed %0d", s), 64'(w), 64'(wmap(2'(s))));
      chk("R4 data per speed", d, expw(16'h40 + s, 0));
    end

    // R5: LRU replacement
    speed_sel = 2'd1; pf_en = 1'b0;
    clean();
    for (int k = 0; k < 4; k++) do_read(mk(16'h10 + k, 0, 0), -1, 0, d, w);
    do_read(mk(16'h10, 0, 0), -1, 0, d, w);
    chk("R5 A still buffered", 64'(w), 64'd0);
    do_read(mk(16'h20, 0, 0), -1, 0, d, w);
    chk("R5 new line misses", 64'(w), 64'd2);
    do_read(mk(16'h10, 0, 0), -1, 0, d, w);
    chk("R5 A kept", 64'(w), 64'd0);
    do_read(mk(16'h12, 0, 0), -1, 0, d, w);
    chk("R5 C kept", 64'(w), 64'd0);
    do_read(mk(16'h13, 0, 0), -1, 0, d, w);
    chk("R5 D kept", 64'(w), 64'd0);
    do_read(mk(16'h11, 1, 0), -1, 0, d, w);
    chk("R5 B was evicted", 64'(w), 64'd2);
    chk("R5 B data", d, expw(16'h11, 1));

    // R6: fetch-ahead
    speed_sel = 2'd2; pf_en = 1'b1;
    clean();
    do_read(mk(16'h30, 0, 0), -1, 0, d, w);
    idle(10);
    do_read(mk(16'h31, 1, 0), -1, 0, d, w);
    chk("R6 next line hits", 64'(w), 64'd0);
    chk("R6 fetched data", d, expw(16'h31, 1));
    pf_en = 1'b0;
    clean();
    do_read(mk(16'h50, 0, 0), -1, 0, d, w);
    idle(10);
    do_read(mk(16'h51, 0, 0), -1, 0, d, w);
    chk("R6 disabled no fetch-ahead", 64'(w), 64'd3);
    pf_en = 1'b1;
    clean();
    do_read(mk(16'hFFFF, 0, 0), -1, 0, d, w);
    idle(10);
    do_read(mk(0, 0, 0), -1, 0, d, w);
    chk("R6 wrap to line 0", 64'(w), 64'd0);
    chk("R6 wrap data", d, expw(0, 0));

    // R7: read miss collides with fetch-ahead launch
    clean();
    do_read(mk(16'h100, 0, 0), -1, 1, d, w);
    do_read(mk(16'h200, 0, 0), -1, 0, d, w);
    chk("R7 read wins array", 64'(w), 64'd3);
    chk("R7 data", d, expw(16'h200, 0));
    idle(10);
    do_read(mk(16'h201, 0, 0), -1, 0, d, w);
    chk("R7 newer target fetched", 64'(w), 64'd0);
    do_read(mk(16'h101, 0, 0), -1, 0, d, w);
    chk("R7 older target dropped", 64'(w), 64'd3);

    // R8: invalidate
    pf_en = 1'b0;
    clean();
    do_read(mk(16'h60, 0, 0), -1, 0, d, w);
    do_read(mk(16'h60, 0, 0), -1, 0, d, w);
    chk("R8 buffered before", 64'(w), 64'd0);
    clean();
    do_read(mk(16'h60, 0, 0), -1, 0, d, w);
    chk("R8 miss after invalidate", 64'(w), 64'd3);
    clean();
    do_read(mk(16'h70, 1, 0), 1, 0, d, w);
    chk("R8 access restarted", 64'(w), 64'd5);
    chk("R8 restarted data", d, expw(16'h70, 1));

    // Random mix: R4 data, R3/R7 wait bound
    for (int b = 0; b < 8; b++) begin
      speed_sel = 2'($urandom % 4);
      pf_en = 1'($urandom % 2);
      idle(8);
      for (int k = 0; k < 40; k++) begin
        int ln;
        bit h;
        bit kp;
        ln = ($urandom % 16 == 0) ? 16'hFFFF : int'($urandom % 12);
        h  = 1'($urandom % 2);
        kp = 1'($urandom % 2);
        do_read(mk(ln, h, int'($urandom % 8)), -1, kp, d, w);
        chk("R4 random data", d, expw(ln, h));
        total++;
        if (w > 2 * wmap(speed_sel) - 1) begin
          bad++;
          $display("FAIL R3 random wait bound actual=%0d expected<=%0d",
                   w, 2 * wmap(speed_sel) - 1);
        end
        if (!kp) idle(int'($urandom % 3));
      end
      req_valid = 1'b0;
    end

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule